// File: doc/BRIEF.md
# Background Memory ECC Scrubber

This engine sweeps main memory in the background, one 144-bit chunk (128 data bits and 16 check bits) at a time. Once a programmable idle gap has elapsed, it requests a read from the memory controller. The returned chunk goes to an external nibble-symbol ECC decoder, and the engine acts on the class that the decoder reports. A clean chunk causes nothing further. A chunk with its damage confined to one aligned nibble is logged and then rewritten with the corrected data at the same address. A chunk with damage in two or more nibbles is logged and left as it is.

Scrub traffic has lower priority than normal traffic. The engine drops its request in any cycle in which the controller reports a normal request pending. The chunk index wraps to zero after a programmable last index. A small log keeps the first event and a sticky flag that records any later event arriving before software clears the log.

Top module: `mem_scrubber`

## Requirements
- R1: While reset is asserted, `mc_req` is 0, `mc_addr` is 0, and `log_valid` and `log_ovf` are 0.
- R2: `mc_req` is 0 in every cycle in which `host_req` is 1. A request waiting for `mc_gnt` keeps `mc_addr` and `mc_we` unchanged.
- R3: The first read request of a step appears exactly `scrub_interval`+3 cycles after the clock edge that accepted the response of a clean chunk, provided `scrub_en` is 1 and `host_req` is 0.
- R4: Reads visit chunk indices 0, 1, … `scrub_limit`, 0, … in order. The byte address on `mc_addr` is the index times 16, so its low 4 bits are zero.
- R5: The decoder class encoding is 2'b00 clean, 2'b01 correctable (one nibble), and 2'b10 or 2'b11 uncorrectable. A clean chunk causes no write and no change to the log.
- R6: A correctable chunk is written back exactly once, with `dec_fixed` as `mc_wdata`, to the address it was read from, before the next read is issued.
- R7: An uncorrectable chunk is never written. When it is the first event, it is logged with `log_uncorr`=1.
- R8: The first event after the log was empty captures its address, its `dec_syn` value and its kind. These fields then hold until `log_clear` is pulsed.
- R9: An event that arrives while `log_valid` is 1 sets `log_ovf`, which stays set until `log_clear`. `log_clear` empties both `log_valid` and `log_ovf`.
- R10: While `scrub_en` is 0, no new step starts. A step already in progress finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_en | input | 1 | Allows new scrub steps to start |
| scrub_interval | input | INTV_W | Idle cycles between steps, minus one |
| scrub_limit | input | ADDR_W-4 | Last chunk index before wrapping |
| host_req | input | 1 | Normal traffic pending; scrub yields |
| mc_req | output | 1 | Scrub request to the memory controller |
| mc_we | output | 1 | 1 = write-back, 0 = read |
| mc_addr | output | ADDR_W | Byte address of the chunk |
| mc_wdata | output | DATA_W+CHK_W | Corrected chunk for the write-back |
| mc_gnt | input | 1 | Controller accepts the request this cycle |
| mc_rvalid | input | 1 | Read data valid |
| mc_rdata | input | DATA_W+CHK_W | Read chunk |
| dec_chunk | output | DATA_W+CHK_W | Captured chunk presented to the decoder |
| dec_class | input | 2 | Decoder error class |
| dec_syn | input | SYN_W | Decoder syndrome |
| dec_fixed | input | DATA_W+CHK_W | Corrected chunk from the decoder |
| log_valid | output | 1 | Log holds an event |
| log_uncorr | output | 1 | Logged event was uncorrectable |
| log_addr | output | ADDR_W | Address of the logged event |
| log_syn | output | SYN_W | Syndrome of the logged event |
| log_ovf | output | 1 | Sticky: a later event was missed |
| log_clear | input | 1 | Empties the log |

## Verification
The bench builds the block with its default widths: a 37-bit byte address, which leaves a 33-bit chunk index, a 144-bit chunk, a 16-bit syndrome and a 16-bit interval. At run time it sets the last index to 7 and the interval to 3, and later to 6. With these values the wrap, two complete passes with their log and overflow sequences, and exact gap measurements all occur within a few hundred cycles. One pass uses random yielding and grants, and the memory model injects a single-nibble flaw and a two-nibble flaw.

// File: rtl/mem_scrubber.sv
module mem_scrubber #(
  parameter int ADDR_W = 37,
  parameter int DATA_W = 128,
  parameter int CHK_W  = 16,
  parameter int SYN_W  = 16,
  parameter int INTV_W = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   scrub_en,
  input  logic [INTV_W-1:0]                      scrub_interval,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]     scrub_limit,
  input  logic                                   host_req,
  output logic                                   mc_req,
  output logic                                   mc_we,
  output logic [ADDR_W-1:0]                      mc_addr,
  output logic [DATA_W+CHK_W-1:0]                mc_wdata,
  input  logic                                   mc_gnt,
  input  logic                                   mc_rvalid,
  input  logic [DATA_W+CHK_W-1:0]                mc_rdata,
  output logic [DATA_W+CHK_W-1:0]                dec_chunk,
  input  logic [1:0]                             dec_class,
  input  logic [SYN_W-1:0]                       dec_syn,
  input  logic [DATA_W+CHK_W-1:0]                dec_fixed,
  output logic                                   log_valid,
  output logic                                   log_uncorr,
  output logic [ADDR_W-1:0]                      log_addr,
  output logic [SYN_W-1:0]                       log_syn,
  output logic                                   log_ovf,
  input  logic                                   log_clear
);
  localparam int CW    = DATA_W + CHK_W;
  localparam int OFS_W = $clog2(DATA_W/8);
  localparam int IDX_W = ADDR_W - OFS_W;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WAIT, S_CLASS, S_WB, S_ADV} st_t;

  st_t               st;
  logic [INTV_W-1:0] cnt;
  logic [IDX_W-1:0]  idx;
  logic [CW-1:0]     rbuf, wbuf;

  wire is_err  = dec_class != 2'b00;
  wire is_corr = dec_class == 2'b01;
  wire evt     = (st == S_CLASS) && is_err;
  wire acc     = mc_req && mc_gnt;

  assign mc_req    = (st == S_READ || st == S_WB) && !host_req;
  assign mc_we     = (st == S_WB);
  assign mc_addr   = {idx, {OFS_W{1'b0}}};
  assign mc_wdata  = wbuf;
  assign dec_chunk = rbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      idx  <= '0;
      rbuf <= '0;
      wbuf <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (!scrub_en) cnt <= '0;
          else if (cnt == scrub_interval) begin
            cnt <= '0;
            st  <= S_READ;
          end else cnt <= cnt + 1'b1;
        end
        S_READ:  if (acc) st <= S_WAIT;
        S_WAIT: begin
          if (mc_rvalid) begin
            rbuf <= mc_rdata;
            st   <= S_CLASS;
          end
        end
        S_CLASS: begin
          if (is_corr) begin
            wbuf <= dec_fixed;
            st   <= S_WB;
          end else st <= S_ADV;
        end
        S_WB:    if (acc) st <= S_ADV;
        S_ADV: begin
          idx <= (idx >= scrub_limit) ? '0 : idx + 1'b1;
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_valid  <= 1'b0;
      log_uncorr <= 1'b0;
      log_addr   <= '0;
      log_syn    <= '0;
      log_ovf    <= 1'b0;
    end else if (evt && (!log_valid || log_clear)) begin
      log_valid  <= 1'b1;
      log_uncorr <= !is_corr;
      log_addr   <= mc_addr;
      log_syn    <= dec_syn;
      log_ovf    <= 1'b0;
    end else if (evt) begin
      log_ovf    <= 1'b1;
    end else if (log_clear) begin
      log_valid  <= 1'b0;
      log_ovf    <= 1'b0;
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_req && !mc_gnt) |=> ($stable(mc_addr) && $stable(mc_we)));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADV && idx >= scrub_limit) |=> (mc_addr == '0));

  assert_clean_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLASS && dec_class == 2'b00) |=> !mc_we);

  assert_log_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_clear) |=> ($stable(log_addr) && $stable(log_syn) && log_valid));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (log_ovf && !log_clear) |=> log_ovf);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !scrub_en) |=> (st == S_IDLE));
endmodule

// File: tb/sim_mem_scrubber.sv
module sim_mem_scrubber;
  localparam int CW = 144;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic          scrub_en = 0, host_req = 0, mc_gnt = 0, mc_rvalid = 0, log_clear = 0;
  logic [15:0]   scrub_interval = 16'd3;
  logic [32:0]   scrub_limit = 33'd7;
  logic [CW-1:0] mc_rdata = '0;
  logic          mc_req, mc_we, log_valid, log_uncorr, log_ovf;
  logic [36:0]   mc_addr, log_addr;
  logic [CW-1:0] mc_wdata, dec_chunk, dec_fixed;
  logic [1:0]    dec_class;
  logic [15:0]   dec_syn, log_syn;

  mem_scrubber u0 (
    .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .scrub_interval(scrub_interval),
    .scrub_limit(scrub_limit), .host_req(host_req), .mc_req(mc_req), .mc_we(mc_we),
    .mc_addr(mc_addr), .mc_wdata(mc_wdata), .mc_gnt(mc_gnt), .mc_rvalid(mc_rvalid),
    .mc_rdata(mc_rdata), .dec_chunk(dec_chunk), .dec_class(dec_class), .dec_syn(dec_syn),
    .dec_fixed(dec_fixed), .log_valid(log_valid), .log_uncorr(log_uncorr),
    .log_addr(log_addr), .log_syn(log_syn), .log_ovf(log_ovf), .log_clear(log_clear));

  int checks = 0, fails = 0;
  logic [CW-1:0] golden [8];
  logic [CW-1:0] mem    [8];
  int  wr_cnt [8];
  int  cur_idx = 0, exp_idx = 0, reads_done = 0, lat = 0, gap = 0, gaps_done = 0;
  bit  quiet = 0, gap_on = 0, done = 0;

  function automatic int nib_count(logic [CW-1:0] d);
    int n = 0;
    for (int i = 0; i < 36; i++) if (d[i*4 +: 4] != 4'h0) n++;
    return n;
  endfunction

  function automatic logic [15:0] syn_of(logic [CW-1:0] d);
    int first = 0;
    for (int i = 35; i >= 0; i--) if (d[i*4 +: 4] != 4'h0) first = i;
    return {8'(first), d[first*4 +: 4], 4'(nib_count(d))};
  endfunction

  always_comb begin
    dec_fixed = golden[cur_idx];
    dec_syn   = syn_of(dec_chunk ^ golden[cur_idx]);
    case (nib_count(dec_chunk ^ golden[cur_idx]))
      0:       dec_class = 2'b00;
      1:       dec_class = 2'b01;
      default: dec_class = 2'b10;
    endcase
  end

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory controller and host traffic model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        check(!(host_req && mc_req), "R2 yield", mc_req, 0);
        if (gap_on) begin
          gap++;
          if (mc_req && !mc_we) begin
            check(gap == int'(scrub_interval) + 4, "R3 gap", gap, int'(scrub_interval) + 4);
            gap_on = 0;
            gaps_done++;
          end
        end
        mc_rvalid = 0;
        if (lat > 0) begin
          lat--;
          if (lat == 0) begin
            mc_rvalid = 1;
            mc_rdata  = mem[cur_idx];
            if (quiet && mem[cur_idx] == golden[cur_idx]) begin
              gap_on = 1;
              gap    = 0;
            end
          end
        end
        host_req = quiet ? 1'b0 : ($urandom % 4 == 0);
        mc_gnt   = quiet ? 1'b1 : ($urandom % 3 != 0);
        #1;
        if (mc_req && mc_gnt) begin
          if (!mc_we) begin
            check(mc_addr == 37'(exp_idx * 16), "R4 order", mc_addr, exp_idx * 16);
            cur_idx = exp_idx;
            exp_idx = (exp_idx == 7) ? 0 : exp_idx + 1;
            reads_done++;
            lat = quiet ? 1 : 1 + int'($urandom % 3);
          end else begin
            check(mc_addr == 37'(cur_idx * 16), "R6 wb addr", mc_addr, cur_idx * 16);
            check(mc_wdata == golden[cur_idx], "R6 wb data", mc_wdata[127:0], golden[cur_idx][127:0]);
            mem[cur_idx] = mc_wdata;
            wr_cnt[cur_idx]++;
          end
        end
      end
    end
  end

  initial begin
    int others;
    bit seen;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin
      golden[i] = {$urandom, $urandom, $urandom, $urandom, $urandom};
      mem[i]    = golden[i];
      wr_cnt[i] = 0;
    end
    mem[2] = golden[2] ^ (144'h9 << (4*17));
    mem[5] = golden[5] ^ (144'h3 << 8) ^ (144'h1 << (4*30));

    repeat (3) @(negedge clk);
    check(mc_req == 0, "R1 req", mc_req, 0);
    check(mc_addr == 0, "R1 addr", mc_addr, 0);
    check(log_valid == 0 && log_ovf == 0, "R1 log", {log_valid, log_ovf}, 0);
    rst_n = 1;
    scrub_en = 1;

    wait (reads_done == 9);
    check(log_valid == 1, "R8 valid", log_valid, 1);
    check(log_addr == 37'd32, "R8 addr", log_addr, 32);
    check(log_syn == {8'd17, 4'h9, 4'd1}, "R8 syn", log_syn, {8'd17, 4'h9, 4'd1});
    check(log_uncorr == 0, "R8 kind", log_uncorr, 0);
    check(log_ovf == 1, "R9 ovf set", log_ovf, 1);
    @(negedge clk);
    log_clear = 1;
    @(negedge clk);
    log_clear = 0;
    check(log_valid == 0 && log_ovf == 0, "R9 clear", {log_valid, log_ovf}, 0);

    wait (reads_done == 17);
    check(log_valid == 1 && log_addr == 37'd80, "R7 addr", log_addr, 80);
    check(log_uncorr == 1, "R7 kind", log_uncorr, 1);
    check(log_syn == {8'd2, 4'h3, 4'd2}, "R7 syn", log_syn, {8'd2, 4'h3, 4'd2});
    check(log_ovf == 0, "R9 no ovf", log_ovf, 0);
    check(wr_cnt[2] == 1, "R6 once", wr_cnt[2], 1);
    check(mem[2] == golden[2], "R6 fixed", mem[2][127:0], golden[2][127:0]);
    check(wr_cnt[5] == 0 && mem[5] != golden[5], "R7 no write", wr_cnt[5], 0);
    others = 0;
    for (int i = 0; i < 8; i++) if (i != 2 && i != 5) others += wr_cnt[i];
    check(others == 0, "R5 clean no write", others, 0);

    scrub_en = 0;
    repeat (30) @(negedge clk);
    seen = 0;
    repeat (30) begin
      @(negedge clk);
      if (mc_req) seen = 1;
    end
    check(!seen, "R10 disabled", seen, 0);

    scrub_interval = 16'd6;
    quiet = 1;
    scrub_en = 1;
    wait (gaps_done >= 3);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule